// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block holds the status flags of a UART and merges four interrupt sources into a single interrupt line. The receive path gives it an error tag for the character at the head of its FIFO: parity error, frame error and break. It also receives one-cycle overrun events and the empty and full levels of both FIFOs. The four active-low modem inputs enter asynchronously.

The block presents two registered status words, one for the line and one for the modem. It also presents a pending flag for each interrupt source and one registered interrupt output. Each pending flag is gated by its own enable bit before the sources are combined.

CPU read strobes from the bus decoder cause the clear-on-read side effects:
- A data-port read moves the character error flags on to the next character in the receive FIFO.
- A line-status read clears overrun.
- A modem-status read clears the change flags.

Top module: `uart_si_top`

## Requirements
- R1: During and after reset, with the transmit FIFO empty and not full and the receive FIFO empty, the line status word is 0x41 and the modem status word is 0x00.
- R2: Line status bit positions are: bit 6 transmit FIFO empty, bit 5 break, bit 4 frame error, bit 3 overrun, bit 2 parity error, bit 1 receive FIFO not empty, bit 0 transmit FIFO not full. Bit 7 reads 0.
- R3: The parity, frame and break flags are captured from the head-of-FIFO tags when data first becomes available. After that they change only when a data-port read loads the next character's tags. If the next character is clean, the flags clear. When the receive FIFO is empty, all three flags read 0.
- R4: An overrun event sets a sticky overrun flag, and a line-status read clears it. An event in the same cycle as the read leaves the flag set. A data-port read does not clear it.
- R5: Modem status bit positions are: bit 7 ring trailing edge, bit 6 carrier-detect change, bit 5 clear-to-send change, bit 4 data-set-ready change, and bits 3..0 the synchronized active-high levels of ring, carrier detect, clear-to-send and data-set-ready.
- R6: The carrier-detect, clear-to-send and data-set-ready change flags set on any change of their synchronized level. The ring flag sets only when the ring level goes from active to inactive.
- R7: A modem-status read clears all four change flags. A change detected in the same cycle as that read stays set.
- R8: The pending flags use these bit positions: bit 3 modem (any change flag set), bit 2 line (break, frame, overrun or parity set), bit 1 receive (receive FIFO not empty) and bit 0 transmit (transmit FIFO empty).
- R9: The interrupt output is a registered OR of each pending source ANDed with its enable bit, using the same bit positions as the pending flags. A source with its enable bit clear cannot raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_par | input | 1 | Parity-error tag of the character at the receive FIFO head |
| head_frm | input | 1 | Frame-error tag of the head character |
| head_brk | input | 1 | Break tag of the head character (its byte is 0x00) |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| ovr_evt | input | 1 | One-cycle receive overrun event |
| rd_data | input | 1 | Data-port read strobe (pops the receive FIFO) |
| rd_lsr | input | 1 | Line status read strobe |
| rd_msr | input | 1 | Modem status read strobe |
| ring_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ien | input | 4 | Per-source interrupt enables |
| lsr | output | 8 | Line status word |
| msr | output | 8 | Modem status word |
| irq_pend | output | 4 | Per-source pending flags |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a modem-input change that coincides exactly with a modem-status read. The change passes through the synchronizer and then the edge detector, so it reaches the flag register three clock edges after the pin moves. The bench drives the pin and, two cycles later, raises the read strobe for precisely one cycle, so that the read lands on the same edge as the flag set. It then checks that the flag survived.

A second case is the overrun event that arrives together with a line-status read. The bench also checks that changing the head tags without a data read leaves the character flags unchanged.

// File: rtl/uart_si_pkg.sv
package uart_si_pkg;
  // interrupt source positions
  localparam int SRC_N    = 4;
  localparam int SRC_TX   = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_LINE = 2;
  localparam int SRC_MDM  = 3;
  // modem line positions inside the 4-bit level/change vectors
  localparam int MDM_N   = 4;
  localparam int MDM_DSR = 0;
  localparam int MDM_CTS = 1;
  localparam int MDM_DCD = 2;
  localparam int MDM_RI  = 3;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;
endpackage

// File: rtl/uart_si_sync.sv
module uart_si_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_si_modem.sv
module uart_si_modem
  import uart_si_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [MDM_N-1:0] lvl,
  input  logic             rd_msr,
  output logic [MDM_N-1:0] delta
);
  logic [MDM_N-1:0] prev;
  logic [MDM_N-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < MDM_N; g++) begin : g_line
      if (g == MDM_RI) begin : g_trail
        // active -> inactive only
        assign hit[g] = prev[g] & ~lvl[g];
      end else begin : g_any
        assign hit[g] = prev[g] ^ lvl[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      delta <= '0;
    end else begin
      prev  <= lvl;
      delta <= hit | (delta & {MDM_N{~rd_msr}});
    end
  end
endmodule

// File: rtl/uart_si_line.sv
module uart_si_line
  import uart_si_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  rx_tag_t head,
  input  logic    rx_empty,
  input  logic    rd_data,
  input  logic    ovr_evt,
  input  logic    rd_lsr,
  output rx_tag_t cur,
  output logic    ovr
);
  logic loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      loaded <= 1'b0;
    end else if (rx_empty) begin
      cur    <= '0;
      loaded <= 1'b0;
    end else if (rd_data) begin
      loaded <= 1'b0;
    end else if (!loaded) begin
      cur    <= head;
      loaded <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovr <= 1'b0;
    else     ovr <= ovr_evt | (ovr & ~rd_lsr);
  end
endmodule

// File: rtl/uart_si_top.sv
module uart_si_top
  import uart_si_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_par,
  input  logic             head_frm,
  input  logic             head_brk,
  input  logic             rx_empty,
  input  logic             tx_empty,
  input  logic             tx_full,
  input  logic             ovr_evt,
  input  logic             rd_data,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             ring_n,
  input  logic             dcd_n,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic [SRC_N-1:0] ien,
  output logic [7:0]       lsr,
  output logic [7:0]       msr,
  output logic [SRC_N-1:0] irq_pend,
  output logic             irq
);
  logic [MDM_N-1:0] raw_n, sync_n, lvl, delta;
  rx_tag_t          head, cur;
  logic             ovr;
  logic [SRC_N-1:0] pend_d;

  assign raw_n[MDM_RI]  = ring_n;
  assign raw_n[MDM_DCD] = dcd_n;
  assign raw_n[MDM_CTS] = cts_n;
  assign raw_n[MDM_DSR] = dsr_n;

  uart_si_sync #(.W(MDM_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
    .clk(clk), .rst(rst), .din(raw_n), .dout(sync_n)
  );
  assign lvl = ~sync_n;

  uart_si_modem i_modem (
    .clk(clk), .rst(rst), .lvl(lvl), .rd_msr(rd_msr), .delta(delta)
  );

  assign head = '{brk: head_brk, frm: head_frm, par: head_par};

  uart_si_line i_line (
    .clk(clk), .rst(rst), .head(head), .rx_empty(rx_empty), .rd_data(rd_data),
    .ovr_evt(ovr_evt), .rd_lsr(rd_lsr), .cur(cur), .ovr(ovr)
  );

  always_comb begin
    pend_d           = '0;
    pend_d[SRC_TX]   = tx_empty;
    pend_d[SRC_RX]   = ~rx_empty;
    pend_d[SRC_LINE] = cur.brk | cur.frm | cur.par | ovr;
    pend_d[SRC_MDM]  = |delta;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lsr      <= 8'h41;
      msr      <= 8'h00;
      irq_pend <= '0;
      irq      <= 1'b0;
    end else begin
      lsr      <= {1'b0, tx_empty, cur.brk, cur.frm, ovr, cur.par, ~rx_empty, ~tx_full};
      msr      <= {delta[MDM_RI], delta[MDM_DCD], delta[MDM_CTS], delta[MDM_DSR],
                   lvl[MDM_RI], lvl[MDM_DCD], lvl[MDM_CTS], lvl[MDM_DSR]};
      irq_pend <= pend_d;
      irq      <= |(pend_d & ien);
    end
  end
endmodule

// File: rtl/uart_si_chk.sv
module uart_si_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_empty,
  input logic       tx_empty,
  input logic       ovr_evt,
  input logic       rd_lsr,
  input logic [3:0] ien,
  input logic [7:0] lsr,
  input logic [3:0] irq_pend,
  input logic       irq
);
  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |-> ##2 lsr[3]);
  // R4
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr && !ovr_evt) |-> ##2 !lsr[3]);
  // R8
  rx_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_empty |=> irq_pend[1]);
  // R8
  tx_pend_chk: assert property (@(posedge clk) disable iff (rst)
    tx_empty |=> irq_pend[0]);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ien == 4'h0) |=> !irq);
endmodule

bind uart_si_top uart_si_chk i_uart_si_chk (
  .clk(clk), .rst(rst), .rx_empty(rx_empty), .tx_empty(tx_empty),
  .ovr_evt(ovr_evt), .rd_lsr(rd_lsr), .ien(ien), .lsr(lsr),
  .irq_pend(irq_pend), .irq(irq)
);

// File: tb/test_uart_si_top.sv
module test_uart_si_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, head_par, head_frm, head_brk, rx_empty, tx_empty, tx_full;
  logic ovr_evt, rd_data, rd_lsr, rd_msr, ring_n, dcd_n, cts_n, dsr_n;
  logic [3:0] ien, irq_pend;
  logic [7:0] lsr, msr;
  logic irq;

  uart_si_top i_uart_si_top (
    .clk(clk), .rst(rst), .head_par(head_par), .head_frm(head_frm),
    .head_brk(head_brk), .rx_empty(rx_empty), .tx_empty(tx_empty),
    .tx_full(tx_full), .ovr_evt(ovr_evt), .rd_data(rd_data), .rd_lsr(rd_lsr),
    .rd_msr(rd_msr), .ring_n(ring_n), .dcd_n(dcd_n), .cts_n(cts_n),
    .dsr_n(dsr_n), .ien(ien), .lsr(lsr), .msr(msr), .irq_pend(irq_pend),
    .irq(irq)
  );

  typedef struct {
    string      req;
    logic [7:0] lsr;
    logic [7:0] msr;
    logic [3:0] pend;
    logic       irq;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [7:0] l, logic [7:0] m,
                            logic [3:0] p, logic i);
    exp_t e;
    e.req = req; e.lsr = l; e.msr = m; e.pend = p; e.irq = i;
    q.push_back(e);
  endtask

  task automatic pulse_rd_data();
    rd_data = 1'b1; step(1); rd_data = 1'b0;
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (lsr !== e.lsr || msr !== e.msr || irq_pend !== e.pend || irq !== e.irq) begin
          errors++;
          $display("FAIL %s: lsr=%h msr=%h pend=%b irq=%b expected lsr=%h msr=%h pend=%b irq=%b",
                   e.req, lsr, msr, irq_pend, irq, e.lsr, e.msr, e.pend, e.irq);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; head_par = 0; head_frm = 0; head_brk = 0; rx_empty = 1;
    tx_empty = 1; tx_full = 0; ovr_evt = 0; rd_data = 0; rd_lsr = 0; rd_msr = 0;
    ring_n = 1; dcd_n = 1; cts_n = 1; dsr_n = 1; ien = 4'hF;
    step(3);
    expect_out("R1 in reset", 8'h41, 8'h00, 4'b0000, 1'b0);
    rst = 0;
    step(2);
    expect_out("R1 after reset", 8'h41, 8'h00, 4'b0001, 1'b1);
    step(1);

    // R2 R3: first character has a parity error
    head_par = 1; rx_empty = 0;
    step(3);
    expect_out("R3 parity captured", 8'h47, 8'h00, 4'b0111, 1'b1);
    // R3: tags change without a read: flags unchanged
    head_par = 0; head_frm = 1;
    step(3);
    expect_out("R3 no refresh without read", 8'h47, 8'h00, 4'b0111, 1'b1);
    // R3: read loads next (frame error) character
    pulse_rd_data();
    step(3);
    expect_out("R3 frame after read", 8'h53, 8'h00, 4'b0111, 1'b1);
    head_frm = 0; head_brk = 1;
    pulse_rd_data();
    step(3);
    expect_out("R3 break after read", 8'h63, 8'h00, 4'b0111, 1'b1);
    head_brk = 0;
    pulse_rd_data();
    step(3);
    expect_out("R3 clean next char", 8'h43, 8'h00, 4'b0011, 1'b1);
    head_par = 1;
    pulse_rd_data();
    step(3);
    expect_out("R3 parity again", 8'h47, 8'h00, 4'b0111, 1'b1);
    rx_empty = 1; head_par = 0;
    step(3);
    expect_out("R3 empty clears", 8'h41, 8'h00, 4'b0001, 1'b1);

    // R4 overrun
    ovr_evt = 1; step(1); ovr_evt = 0;
    step(2);
    expect_out("R4 overrun set", 8'h49, 8'h00, 4'b0101, 1'b1);
    pulse_rd_data();
    step(3);
    expect_out("R4 data read keeps overrun", 8'h49, 8'h00, 4'b0101, 1'b1);
    ovr_evt = 1; rd_lsr = 1; step(1); ovr_evt = 0; rd_lsr = 0;
    step(2);
    expect_out("R4 event beats read", 8'h49, 8'h00, 4'b0101, 1'b1);
    rd_lsr = 1; step(1); rd_lsr = 0;
    step(2);
    expect_out("R4 read clears", 8'h41, 8'h00, 4'b0001, 1'b1);

    // R2 R8 transmit levels
    tx_empty = 0;
    step(2);
    expect_out("R8 tx holds data", 8'h01, 8'h00, 4'b0000, 1'b0);
    tx_full = 1;
    step(2);
    expect_out("R2 tx full", 8'h00, 8'h00, 4'b0000, 1'b0);
    tx_full = 0; tx_empty = 1; ien = 4'h0;
    step(2);
    expect_out("R9 masked", 8'h41, 8'h00, 4'b0001, 1'b0);
    ien = 4'b1110;
    step(2);
    expect_out("R9 tx disabled", 8'h41, 8'h00, 4'b0001, 1'b0);

    // R5 R6 modem
    ien = 4'b1000;
    cts_n = 0;
    step(6);
    expect_out("R6 cts change", 8'h41, 8'h22, 4'b1001, 1'b1);
    rd_msr = 1; step(1); rd_msr = 0;
    step(3);
    expect_out("R7 read clears", 8'h41, 8'h02, 4'b0001, 1'b0);
    ring_n = 0;
    step(6);
    expect_out("R6 ring leading edge ignored", 8'h41, 8'h0A, 4'b0001, 1'b0);
    ring_n = 1;
    step(6);
    expect_out("R6 ring trailing edge", 8'h41, 8'h82, 4'b1001, 1'b1);
    rd_msr = 1; step(1); rd_msr = 0;
    step(3);
    expect_out("R7 ring cleared", 8'h41, 8'h02, 4'b0001, 1'b0);
    dcd_n = 0;
    step(6);
    expect_out("R5 dcd change", 8'h41, 8'h46, 4'b1001, 1'b1);
    rd_msr = 1; step(1); rd_msr = 0;
    step(3);
    // R7: dsr change lands on the same edge as the read
    dsr_n = 0;
    step(2);
    rd_msr = 1; step(1); rd_msr = 0;
    step(3);
    expect_out("R7 change during read stays", 8'h41, 8'h17, 4'b1001, 1'b1);

    step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule